// File: doc/BRIEF.md
# Video Raster Timing Generator with Counter Capture

This block produces horizontal and vertical raster timing for a display pipe. A horizontal state machine walks through active, right-border and sync phases once per line, and it advances the line counter each time it enters sync. A vertical state machine steps through six phases: active, bottom border, bottom blanking, sync, top blanking and top border. The phase end points come from tables that depend on the 60 Hz or 50 Hz region, the vertical resolution and the horizontal width. The block drives horizontal and vertical blank. It keeps an internal blank flag that follows the display-enable bit. In interlace modes it toggles a field flag.

Software writes a 16-bit control word. It can capture the counters by reading the external-control register, or it can let an external strobe capture them. Each captured count is remapped so that it runs upward from a negative offset while the raster is in sync. A status word shows the capture flag, the internal blank, the horizontal blank, the field flag and the region.

The horizontal phase lengths are parameters. A bench can therefore shorten lines without changing any vertical behaviour.

Top module: `raster_timing`

States, horizontal (`hphase_t`): H_ACT → H_BRD when the count reaches the active end. H_BRD → H_SYNC when it reaches the border end; this transition advances the line. H_SYNC → H_ACT at the line total, where the count wraps to 0.

States, vertical (`vphase_t`): V_ACT → V_BBRD → V_BBLK → V_SYNC → V_TBLK → V_TBRD → V_ACT. A transition is taken when the line count reaches the end of the current phase. Several transitions may happen on one line step. The move V_TBRD → V_ACT subtracts the frame total from the count.

## Requirements
- R1: `hcount` (9 bits) rises by one on each cycle with `pix_ce` high.
  - The phase ends are the parameters H_ACT_*, H_BRD_* and H_TOT_*, which default to 0x140/0x15B/0x1AB in the narrow mode and 0x160/0x177/0x1C7 in the wide mode. Control bit 0 selects the wide mode.
  - At the end of sync the count wraps to 0.
  - `hblank` is high in every phase except active.
- R2: `vcount` (9 bits) rises by one only on the cycle in which the horizontal sequence goes from border to sync.
- R3: In the 60 Hz region (`pal_sel`=0), the line where each vertical phase ends is as follows. The phases are active, bottom border, bottom blanking, sync, top blanking and top border.
  - Vertical modes 0 and 2: 0xE0, 0xE8, 0xED, 0xF0, 0xFF, 0x107.
  - Vertical modes 1 and 3: 0xF0, 0xF0, 0xF5, 0xF8, 0x107, 0x107.
  - Reaching the last value wraps the count back to line 0.
- R4: In the 50 Hz region (`pal_sel`=1) the frame is 0x139 lines, and top blanking starts 3 lines after sync starts. The other start lines, given as bottom border / bottom blanking / sync / top border, are:
  - mode 0: 0xE0 / 0x100 / 0x103 / 0x119
  - mode 1: 0xF0 / 0x108 / 0x10B / 0x121
  - modes 2 and 3: 0x100 / 0x110 / 0x113 / 0x129
- R5: `vblank` goes high when the vertical sequence leaves active for bottom border. It goes low on the line step where `vcount` becomes total − 1. It is 0 after reset.
- R6: Interlace behaviour depends on the interlace field.
  - When the field is nonzero, bottom blanking ends one line early.
  - On each entry to sync the odd flag inverts, and if it becomes 1 the line count gains one extra line.
  - When the field is 0, entry to sync forces the odd flag to 1.
- R7: The internal blank flag is set as follows:
  - On entry to active it takes the inverse of display-on.
  - On entry to bottom border it becomes 1.
  - While display-on is 0 it is 1 from the next cycle on.
- R8: The captured line value is formed in three steps.
  - First it is `vcount`, or (`vcount` + 0x200 − frame total) mod 0x200 when the vertical phase is sync, top blanking or top border.
  - In double-density interlace (field = 3) this value is shifted left by one, with the inverted odd flag in bit 0.
  - In all other modes it is zero-extended to 10 bits.
- R9: The captured pixel value is 2 × `hcount`, or 2 × ((`hcount` + 0x200 − line total) mod 0x200) during horizontal sync. A pulse on `cnt_latch_rd` captures both counts when `ext_latch_en` is 0; with `ext_latch_en` at 1 it has no effect. Without a capture, both captured values hold.
- R10: When `ext_latch_en` is 1, a pulse on `ext_latch_stb` captures both counts and sets status bit 9. A pulse on `stat_rd` clears bit 9; if a strobe arrives in the same cycle, the set wins.
- R11: `status_word` reads as follows; all other bits are 0:
  - bit 9: capture flag
  - bit 3: internal blank
  - bit 2: `hblank`
  - bit 1: odd flag
  - bit 0: `pal_sel`
- R12: A control write (`ctrl_we`) takes effect from the next cycle.
  - Bit fields: display-on is bit 15, the interlace field is bits 7:6, the vertical mode is bits 5:4, the width select is bit 0, and the other bits are ignored.
  - Reset state: counters 0, both sequences in active, display off, internal blank 1, odd 1, flag 0, captured values 0, so `status_word` = 0x000A with `pal_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable; one horizontal count per enabled cycle |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word data |
| pal_sel | input | 1 | Region select: 1 = 50 Hz tables |
| ext_latch_en | input | 1 | Hands capture over to the external strobe |
| ext_latch_stb | input | 1 | External capture strobe |
| cnt_latch_rd | input | 1 | Read of the external-control register (software capture) |
| stat_rd | input | 1 | Read of the status word (clears the capture flag) |
| hcount | output | 9 | Horizontal counter |
| vcount | output | 9 | Line counter |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| status_word | output | 16 | Status word |
| lat_hcount | output | 10 | Captured pixel count |
| lat_vcount | output | 10 | Captured line count |

## Verification
The bench covers every table row in both regions, with each vertical mode run across full frames, so that a wrong end line shifts `vcount` or `vblank` by a line. In the zero-length phases of 60 Hz modes 1 and 3, a design that takes one transition per line step lags behind by lines. Interlace frames check the early sync entry and the extra line on odd fields; a design that adds the line on even fields or never toggles the flag drifts against the predicted count. Captures are taken often enough to land in sync phases and in double-density mode, which catches a missing offset or an uninverted odd bit. External strobes, status reads and ignored software reads expose a wrong priority between set and clear, or a capture path that is not gated.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int CNT_W = 9;

    typedef enum logic [1:0] {
        H_ACT,
        H_BRD,
        H_SYNC
    } hphase_t;

    typedef enum logic [2:0] {
        V_ACT,
        V_BBRD,
        V_BBLK,
        V_SYNC,
        V_TBLK,
        V_TBRD
    } vphase_t;

    // Last-plus-one line of a vertical phase for the given region and mode.
    function automatic logic [CNT_W-1:0] v_end(input logic pal,
                                               input logic [1:0] vres,
                                               input vphase_t ph);
        logic [CNT_W-1:0] row [6];
        if (!pal) begin
            if (!vres[0]) row = '{9'h0E0, 9'h0E8, 9'h0ED, 9'h0F0, 9'h0FF, 9'h107};
            else          row = '{9'h0F0, 9'h0F0, 9'h0F5, 9'h0F8, 9'h107, 9'h107};
        end else begin
            unique case (vres)
                2'd0:    row = '{9'h0E0, 9'h100, 9'h103, 9'h106, 9'h119, 9'h139};
                2'd1:    row = '{9'h0F0, 9'h108, 9'h10B, 9'h10E, 9'h121, 9'h139};
                default: row = '{9'h100, 9'h110, 9'h113, 9'h116, 9'h129, 9'h139};
            endcase
        end
        return row[int'(ph)];
    endfunction

endpackage

// File: rtl/raster_hseq.sv
module raster_hseq
    import raster_pkg::*;
#(
    parameter int H_ACT_N = 320,
    parameter int H_BRD_N = 347,
    parameter int H_TOT_N = 427,
    parameter int H_ACT_W = 352,
    parameter int H_BRD_W = 375,
    parameter int H_TOT_W = 455
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ce,
    input  logic             wide,
    output logic [CNT_W-1:0] hcount,
    output hphase_t          hph,
    output logic             hblank,
    output logic             line_adv,
    output logic [CNT_W-1:0] htot
);

    localparam logic [CNT_W-1:0] A_N = CNT_W'(H_ACT_N);
    localparam logic [CNT_W-1:0] B_N = CNT_W'(H_BRD_N);
    localparam logic [CNT_W-1:0] T_N = CNT_W'(H_TOT_N);
    localparam logic [CNT_W-1:0] A_W = CNT_W'(H_ACT_W);
    localparam logic [CNT_W-1:0] B_W = CNT_W'(H_BRD_W);
    localparam logic [CNT_W-1:0] T_W = CNT_W'(H_TOT_W);

    hphase_t          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim;

    assign htot = wide ? T_W : T_N;

    always_comb begin
        unique case (st_q)
            H_ACT:   lim = wide ? A_W : A_N;
            H_BRD:   lim = wide ? B_W : B_N;
            H_SYNC:  lim = htot;
            default: lim = htot;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        line_adv = 1'b0;
        if (pix_ce) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_d >= lim) begin
                unique case (st_q)
                    H_ACT:   st_d = H_BRD;
                    H_BRD: begin
                        st_d     = H_SYNC;
                        line_adv = 1'b1;
                    end
                    H_SYNC: begin
                        st_d  = H_ACT;
                        cnt_d = cnt_d - htot;
                    end
                    default: st_d = H_ACT;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= H_ACT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        hcount = cnt_q;
        hph    = st_q;
        hblank = (st_q != H_ACT);
    end

endmodule

// File: rtl/raster_vseq.sv
module raster_vseq
    import raster_pkg::*;
#(
    parameter int N_VPH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_adv,
    input  logic             pal,
    input  logic [1:0]       vres,
    input  logic             intl_on,
    input  logic             disp_on,
    output logic [CNT_W-1:0] vcount,
    output vphase_t          vph,
    output logic             vblank,
    output logic             iblank,
    output logic             odd,
    output logic [CNT_W-1:0] vtot
);

    vphase_t          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             vb_q, vb_d, ib_q, ib_d, odd_q, odd_d;
    logic [CNT_W-1:0] lim;
    logic             go;

    assign vtot = v_end(pal, vres, V_TBRD);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        vb_d  = vb_q;
        ib_d  = ib_q | ~disp_on;
        odd_d = odd_q;
        go    = 1'b1;
        lim   = '0;
        if (line_adv) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_d == vtot - 1'b1) vb_d = 1'b0;
            // zero-length phases need several transitions on one line step
            for (int k = 0; k < N_VPH; k++) begin
                lim = v_end(pal, vres, st_d)
                    - ((st_d == V_BBLK && intl_on) ? 9'd1 : 9'd0);
                if (go && cnt_d >= lim) begin
                    unique case (st_d)
                        V_ACT: begin
                            st_d = V_BBRD;
                            ib_d = 1'b1;
                            vb_d = 1'b1;
                        end
                        V_BBRD: st_d = V_BBLK;
                        V_BBLK: begin
                            st_d = V_SYNC;
                            if (intl_on) begin
                                odd_d = ~odd_d;
                                cnt_d = cnt_d + {8'd0, odd_d};
                            end else begin
                                odd_d = 1'b1;
                            end
                        end
                        V_SYNC: st_d = V_TBLK;
                        V_TBLK: st_d = V_TBRD;
                        V_TBRD: begin
                            st_d  = V_ACT;
                            cnt_d = cnt_d - vtot;
                            ib_d  = ~disp_on;
                        end
                        default: st_d = V_ACT;
                    endcase
                end else begin
                    go = 1'b0;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= V_ACT;
            cnt_q <= '0;
            vb_q  <= 1'b0;
            ib_q  <= 1'b1;
            odd_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            vb_q  <= vb_d;
            ib_q  <= ib_d;
            odd_q <= odd_d;
        end
    end

    // outputs
    always_comb begin
        vcount = cnt_q;
        vph    = st_q;
        vblank = vb_q;
        iblank = ib_q;
        odd    = odd_q;
    end

endmodule

// File: rtl/raster_hvlatch.sv
module raster_hvlatch
    import raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] hcount,
    input  hphase_t          hph,
    input  logic [CNT_W-1:0] htot,
    input  logic [CNT_W-1:0] vcount,
    input  vphase_t          vph,
    input  logic [CNT_W-1:0] vtot,
    input  logic             dbl,
    input  logic             odd,
    input  logic             sw_req,
    input  logic             ext_en,
    input  logic             ext_stb,
    input  logic             stat_rd,
    output logic [CNT_W:0]   lat_h,
    output logic [CNT_W:0]   lat_v,
    output logic             flag
);

    logic [CNT_W:0]   h_ofs, v_ofs;
    logic [CNT_W-1:0] h_val, v_val;
    logic             take_sw, take_hw;

    assign take_sw = sw_req & ~ext_en;
    assign take_hw = ext_stb & ext_en;

    always_comb begin
        h_ofs = {1'b0, hcount} + 10'h200 - {1'b0, htot};
        v_ofs = {1'b0, vcount} + 10'h200 - {1'b0, vtot};
        h_val = (hph == H_SYNC) ? h_ofs[CNT_W-1:0] : hcount;
        v_val = (vph inside {V_SYNC, V_TBLK, V_TBRD}) ? v_ofs[CNT_W-1:0] : vcount;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_h <= '0;
            lat_v <= '0;
            flag  <= 1'b0;
        end else begin
            if (take_sw || take_hw) begin
                lat_h <= {h_val, 1'b0};
                lat_v <= dbl ? {v_val, ~odd} : {1'b0, v_val};
            end
            if (take_hw)      flag <= 1'b1;
            else if (stat_rd) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
#(
    parameter int H_ACT_N = 320,
    parameter int H_BRD_N = 347,
    parameter int H_TOT_N = 427,
    parameter int H_ACT_W = 352,
    parameter int H_BRD_W = 375,
    parameter int H_TOT_W = 455
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_ce,
    input  logic        ctrl_we,
    input  logic [15:0] ctrl_wdata,
    input  logic        pal_sel,
    input  logic        ext_latch_en,
    input  logic        ext_latch_stb,
    input  logic        cnt_latch_rd,
    input  logic        stat_rd,
    output logic [8:0]  hcount,
    output logic [8:0]  vcount,
    output logic        hblank,
    output logic        vblank,
    output logic [15:0] status_word,
    output logic [9:0]  lat_hcount,
    output logic [9:0]  lat_vcount
);

    logic       disp_q, wide_q;
    logic [1:0] intl_q, vres_q;
    logic       unused_ctrl;

    hphase_t          hph;
    vphase_t          vph;
    logic             line_adv, iblank, odd, cap_flag;
    logic [CNT_W-1:0] htot, vtot;

    assign unused_ctrl = ^{ctrl_wdata[14:8], ctrl_wdata[3:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_q <= 1'b0;
            intl_q <= 2'd0;
            vres_q <= 2'd0;
            wide_q <= 1'b0;
        end else if (ctrl_we) begin
            disp_q <= ctrl_wdata[15];
            intl_q <= ctrl_wdata[7:6];
            vres_q <= ctrl_wdata[5:4];
            wide_q <= ctrl_wdata[0];
        end
    end

    raster_hseq #(
        .H_ACT_N(H_ACT_N), .H_BRD_N(H_BRD_N), .H_TOT_N(H_TOT_N),
        .H_ACT_W(H_ACT_W), .H_BRD_W(H_BRD_W), .H_TOT_W(H_TOT_W)
    ) u_hseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_ce   (pix_ce),
        .wide     (wide_q),
        .hcount   (hcount),
        .hph      (hph),
        .hblank   (hblank),
        .line_adv (line_adv),
        .htot     (htot)
    );

    raster_vseq u_vseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_adv (line_adv),
        .pal      (pal_sel),
        .vres     (vres_q),
        .intl_on  (|intl_q),
        .disp_on  (disp_q),
        .vcount   (vcount),
        .vph      (vph),
        .vblank   (vblank),
        .iblank   (iblank),
        .odd      (odd),
        .vtot     (vtot)
    );

    raster_hvlatch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .hcount  (hcount),
        .hph     (hph),
        .htot    (htot),
        .vcount  (vcount),
        .vph     (vph),
        .vtot    (vtot),
        .dbl     (intl_q == 2'd3),
        .odd     (odd),
        .sw_req  (cnt_latch_rd),
        .ext_en  (ext_latch_en),
        .ext_stb (ext_latch_stb),
        .stat_rd (stat_rd),
        .lat_h   (lat_hcount),
        .lat_v   (lat_vcount),
        .flag    (cap_flag)
    );

    assign status_word = {6'd0, cap_flag, 5'd0, iblank, hblank, odd, pal_sel};

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
    import raster_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input hphase_t     hph,
    input vphase_t     vph,
    input logic        disp_q,
    input logic [1:0]  intl_q,
    input logic [8:0]  vcount,
    input logic        vblank,
    input logic [15:0] status_word,
    input logic [9:0]  lat_hcount,
    input logic [9:0]  lat_vcount,
    input logic        cnt_latch_rd,
    input logic        ext_latch_en,
    input logic        ext_latch_stb,
    input logic        stat_rd
);

    assert_vcnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vcount != $past(vcount)) |-> ($past(hph) == H_BRD && hph == H_SYNC));

    assert_vb_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> ($past(vph) == V_ACT && vph != V_ACT));

    assert_odd_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(intl_q) == 2'd0 && vph == V_SYNC && $past(vph) != V_SYNC)
        |-> status_word[1]);

    assert_ib_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_q |=> status_word[3]);

    assert_lat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cnt_latch_rd && !ext_latch_en) && !(ext_latch_stb && ext_latch_en))
        |=> ($stable(lat_hcount) && $stable(lat_vcount)));

    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_latch_en && ext_latch_stb) |=> status_word[9]);

    assert_flag_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(ext_latch_en && ext_latch_stb)) |=> !status_word[9]);

endmodule

bind raster_timing raster_timing_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hph           (hph),
    .vph           (vph),
    .disp_q        (disp_q),
    .intl_q        (intl_q),
    .vcount        (vcount),
    .vblank        (vblank),
    .status_word   (status_word),
    .lat_hcount    (lat_hcount),
    .lat_vcount    (lat_vcount),
    .cnt_latch_rd  (cnt_latch_rd),
    .ext_latch_en  (ext_latch_en),
    .ext_latch_stb (ext_latch_stb),
    .stat_rd       (stat_rd)
);

// File: tb/sim_raster_timing.sv
module sim_raster_timing;

    localparam int HAN = 8,  HBN = 12, HTN = 16;
    localparam int HAW = 10, HBW = 14, HTW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        pal_sel = 1'b0;
    logic        ext_latch_en = 1'b0;
    logic        ext_latch_stb = 1'b0;
    logic        cnt_latch_rd = 1'b0;
    logic        stat_rd = 1'b0;
    logic [8:0]  hcount, vcount;
    logic        hblank, vblank;
    logic [15:0] status_word;
    logic [9:0]  lat_hcount, lat_vcount;

    always #2 clk = ~clk;

    raster_timing #(
        .H_ACT_N(HAN), .H_BRD_N(HBN), .H_TOT_N(HTN),
        .H_ACT_W(HAW), .H_BRD_W(HBW), .H_TOT_W(HTW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .pal_sel(pal_sel), .ext_latch_en(ext_latch_en),
        .ext_latch_stb(ext_latch_stb), .cnt_latch_rd(cnt_latch_rd), .stat_rd(stat_rd),
        .hcount(hcount), .vcount(vcount), .hblank(hblank), .vblank(vblank),
        .status_word(status_word), .lat_hcount(lat_hcount), .lat_vcount(lat_vcount)
    );

    typedef struct {
        int h; int v; bit hb; bit vb; bit ib; bit odd; bit flag; int lh; int lv;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    bit   done = 0;

    // predictor state
    int mh, mhp, mv, mvp, mlh, mlv, mintl, mvres;
    bit mvb, mib, modd, mflag, mdisp, mwide;

    function automatic int m_vend(bit pal, int vres, int ph);
        int t[6];
        if (!pal) begin
            if (vres % 2 == 0) t = '{'h0E0, 'h0E8, 'h0ED, 'h0F0, 'h0FF, 'h107};
            else               t = '{'h0F0, 'h0F0, 'h0F5, 'h0F8, 'h107, 'h107};
        end else if (vres == 0) t = '{'h0E0, 'h100, 'h103, 'h106, 'h119, 'h139};
        else if (vres == 1)     t = '{'h0F0, 'h108, 'h10B, 'h10E, 'h121, 'h139};
        else                    t = '{'h100, 'h110, 'h113, 'h116, 'h129, 'h139};
        return t[ph];
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // predictor: pushes one expected item per clock edge
    always @(posedge clk) begin
        exp_t e;
        int htot, vtot, ht, vt, lim;
        bit adv, go;
        if (!rst_n) begin
            mh = 0; mhp = 0; mv = 0; mvp = 0; mvb = 0; mib = 1; modd = 1; mflag = 0;
            mlh = 0; mlv = 0; mdisp = 0; mintl = 0; mvres = 0; mwide = 0;
        end else begin
            htot = mwide ? HTW : HTN;
            vtot = m_vend(pal_sel, mvres, 5);
            if ((cnt_latch_rd && !ext_latch_en) || (ext_latch_stb && ext_latch_en)) begin
                ht  = (mhp == 2) ? (mh + 512 - htot) % 512 : mh;
                mlh = ht * 2;
                vt  = (mvp >= 3) ? (mv + 512 - vtot) % 512 : mv;
                mlv = (mintl == 3) ? (vt * 2 + (modd ? 0 : 1)) : vt;
            end
            if (ext_latch_stb && ext_latch_en) mflag = 1;
            else if (stat_rd) mflag = 0;
            if (!mdisp) mib = 1;
            adv = 0;
            if (pix_ce) begin
                mh++;
                lim = (mhp == 0) ? (mwide ? HAW : HAN) : (mhp == 1) ? (mwide ? HBW : HBN) : htot;
                if (mh >= lim) begin
                    if (mhp == 2) begin mhp = 0; mh -= htot; end
                    else begin mhp++; if (mhp == 2) adv = 1; end
                end
            end
            if (adv) begin
                mv = (mv + 1) % 512;
                if (mv == vtot - 1) mvb = 0;
                go = 1;
                for (int k = 0; k < 6; k++) begin
                    lim = m_vend(pal_sel, mvres, mvp) - ((mvp == 2 && mintl != 0) ? 1 : 0);
                    if (go && mv >= lim) begin
                        if (mvp == 5) begin mvp = 0; mv -= vtot; mib = !mdisp; end
                        else begin
                            mvp++;
                            if (mvp == 1) begin mib = 1; mvb = 1; end
                            if (mvp == 3) begin
                                if (mintl != 0) begin modd = !modd; mv += modd; end
                                else modd = 1;
                            end
                        end
                    end else go = 0;
                end
            end
            if (ctrl_we) begin
                mdisp = ctrl_wdata[15]; mintl = ctrl_wdata[7:6];
                mvres = ctrl_wdata[5:4]; mwide = ctrl_wdata[0];
            end
        end
        e.h = mh; e.v = mv; e.hb = (mhp != 0); e.vb = mvb; e.ib = mib; e.odd = modd;
        e.flag = mflag; e.lh = mlh; e.lv = mlv;
        q.push_back(e);
    end

    // monitor
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk("R1", "hcount", hcount, e.h);
            chk("R1", "hblank", hblank, e.hb);
            chk(pal_sel ? "R4" : "R3", "vcount R2", vcount, e.v);
            chk("R5", "vblank", vblank, e.vb);
            chk("R6", "odd", status_word[1], e.odd);
            chk("R7", "iblank", status_word[3], e.ib);
            chk("R8", "lat_vcount", lat_vcount, e.lv);
            chk("R9", "lat_hcount", lat_hcount, e.lh);
            chk("R10", "flag", status_word[9], e.flag);
            chk("R11", "status", {status_word[15:10], status_word[8:0]},
                {6'd0, 5'd0, e.ib, e.hb, e.odd, pal_sel});
        end
    end

    // background software reads
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            cnt_latch_rd = (cyc % 97 == 0);
            stat_rd      = (cyc % 211 == 0);
        end
    end

    task automatic wr_ctrl(input logic [15:0] w);
        @(posedge clk); #1;
        ctrl_we = 1'b1; ctrl_wdata = w;
        @(posedge clk); #1;
        ctrl_we = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "reset hcount", hcount, 0);
        chk("R12", "reset vcount", vcount, 0);
        chk("R12", "reset status", status_word, 16'h000A);
        chk("R12", "reset lat", {lat_hcount, lat_vcount}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        run(20);
        chk("R7", "iblank before first active", status_word[3], 1);
        wr_ctrl(16'h8000); run(9000);          // 60 Hz mode 0
        wr_ctrl(16'h8010); run(4500);          // 60 Hz mode 1, zero-length border
        @(posedge clk); #1; pal_sel = 1'b1;
        wr_ctrl(16'h8000); run(5200);          // 50 Hz mode 0
        wr_ctrl(16'h8010); run(5200);          // 50 Hz mode 1
        wr_ctrl(16'h8020); run(5200);          // 50 Hz mode 2
        wr_ctrl(16'h8131); run(6500);          // 50 Hz mode 3, wide, border bit ignored
        @(posedge clk); #1; pal_sel = 1'b0;
        wr_ctrl(16'h8080); run(13000);         // single interlace
        wr_ctrl(16'h80C0); run(13000);         // double interlace
        @(posedge clk); #1; pal_sel = 1'b1;
        run(11000);                            // double interlace, 50 Hz
        @(posedge clk); #1; pal_sel = 1'b0;
        wr_ctrl(16'h00C0); run(3000);          // display off
        wr_ctrl(16'h8000); run(6000);
        @(posedge clk); #1; ext_latch_en = 1'b1;
        for (int i = 0; i < 30; i++) begin     // R10 external strobes
            run(100 + i);
            #1; ext_latch_stb = 1'b1;
            @(posedge clk); #1; ext_latch_stb = 1'b0;
        end
        @(posedge clk); #1; ext_latch_en = 1'b0;
        for (int i = 0; i < 6000; i++) begin   // gated pixel enable
            @(posedge clk); #1;
            pix_ce = (i % 3 != 0);
        end
        pix_ce = 1'b1;
        wr_ctrl(16'h8041); run(9000);          // interlace field 1, wide
        done = 1;
        run(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule